// File: doc/BRIEF.md
# Tick-Driven Reload Down-Counter Timer

This block is a down-counting timer for use as a peripheral. It decrements a counter on every clock cycle in which a count-tick input is high. When the counter passes from zero to all ones, that is an underflow. An underflow sets a sticky flag and, if enabled, raises an interrupt request. After an underflow the timer follows one of two policies. In one-shot mode it stops and waits for a new start. In auto-reload mode it copies the reload value back into the counter and keeps running.

Software controls the timer through a small write/read register port:

- a control word at address 0,
- the reload value at address 1,
- the live counter value at address 2, which is read-only.

A start bit in the control word launches the timer. The start bit takes effect only when the software-start mode code is selected. A dedicated output pin carries one of two waveforms: a level pulse that lasts for the whole one-shot run, or a square wave that inverts at every reload. Its polarity is programmable.

Top module: `tick_reload_timer`

## Requirements
- R1: After reset, all of the following read as 0: the control word (address 0), the reload value (address 1) and the counter (address 2). `irq` and `timerOut` are also 0.
- R2: The control word has these fields, by bit: bit0 run-enable, bit1 start, bit2 irq-enable, bit3 underflow flag, bit4 auto-reload, bit5 output polarity, bits 8:6 mode code. A start makes the counter take the reload value. After that, the counter decrements by one at each clock edge where `countTick` is high, and holds at every other edge.
- R3: When the counter is decremented from 0, it wraps to all ones and the underflow flag (bit3) is set. The flag stays set until a control write with bit3 = 0 clears it. A control write with bit3 = 1 leaves the flag unchanged. If an underflow happens at the same edge as a clearing write, the underflow wins.
- R4: `irq` is high exactly when both the underflow flag and irq-enable (bit2) are 1.
- R5: With auto-reload = 0 (one-shot mode), the timer stops at underflow and the counter holds all ones. A later start loads the reload value and counts again.
- R6: With auto-reload = 1, an underflow loads the reload value into the counter at the same edge, and counting continues without a pause.
- R7: In one-shot mode, `timerOut` equals the inverse of the polarity bit while the timer runs. At all other times it equals the polarity bit.
- R8: In auto-reload mode, `timerOut` equals the polarity bit when the timer starts, and inverts at every underflow.
- R9: A single control write with bit0 = 1, bit1 = 1 and mode code 000 both enables and starts the timer at the same edge. A start is ignored if that write has bit0 = 0 or a nonzero mode code.
- R10: The start bit always reads back as 0.
- R11: A control write with bit0 = 0 stops the timer at that edge. The counter holds its value, and `timerOut` returns to the polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 reload |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address: 0 control, 1 reload, 2 counter |
| rdData | output | 16 | Read data, combinational |
| countTick | input | 1 | Count enable tick |
| irq | output | 1 | Underflow interrupt request |
| timerOut | output | 1 | Timer waveform output |

## Verification
The bench sweeps both underflow policies, both polarities, several reload values including 0, and dense and sparse tick patterns, and compares every cycle against an arithmetic model.

Each corner case targets a specific bug:
- A reload value of 0 underflows on the first tick. A design that compares against 1 instead of detecting the wrap would skip or delay that underflow.
- A one-shot run must freeze at all ones. A design that kept running, or reloaded, would show a counter that keeps changing and an output that never returns to its idle level.
- The flag is written with 1 and then with 0. A design that treated a written 1 as a set or a toggle, or ignored the clear, would be caught at readback.
- A start is attempted while disabled and again with a nonzero mode. A design that honoured either start would leave the counter moving.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // register addresses
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_COUNT  = 2'd2;

  // control word bit positions
  localparam int BIT_EN    = 0;
  localparam int BIT_START = 1;
  localparam int BIT_IE    = 2;
  localparam int BIT_FLAG  = 3;
  localparam int BIT_AR    = 4;
  localparam int BIT_POL   = 5;
  localparam int BIT_MODE  = 6;
  localparam int MODE_W    = 3;
  localparam int CTRL_W    = BIT_MODE + MODE_W;

  localparam logic [MODE_W-1:0] MODE_SOFT = '0;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              polarity;
    logic              autoReload;
    logic              irqEn;
    logic              runEn;
  } ctrlCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic dec;
  } dpStrobe_t;

endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrReload,
  input  logic [CNT_W-1:0] wrData,
  input  dpStrobe_t        strobe,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reloadVal,
  output logic             isZero
);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] reloadQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reloadQ <= '0;
    end else if (wrReload) begin
      reloadQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countQ <= '0;
    end else if (strobe.load) begin
      countQ <= reloadQ;
    end else if (strobe.dec) begin
      countQ <= countQ - CNT_W'(1);
    end
  end

  assign count     = countQ;
  assign reloadVal = reloadQ;
  assign isZero    = (countQ == '0);

  // R2: a load strobe takes the reload value
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> countQ == $past(reloadQ));

  // R2: a plain decrement lowers the count by one
  p_dec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.dec && !strobe.load) |=> countQ == $past(countQ) - CNT_W'(1));

  // R3: decrement from zero wraps to all ones
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.dec && !strobe.load && isZero) |=> &countQ);

  // R2: with no strobe the count holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.dec && !strobe.load) |=> $stable(countQ));

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrCtrl,
  input  logic [CNT_W-1:0] wrData,
  input  logic             countTick,
  input  logic             isZero,
  output dpStrobe_t        strobe,
  output logic [CNT_W-1:0] ctrlWord,
  output logic             irq,
  output logic             timerOut
);

  ctrlCfg_t cfgQ, cfgNext;
  logic     flagQ, flagNext;
  logic     runQ, runNext;
  logic     phaseQ, phaseNext;
  logic     startNow, decNow, underflow;

  always_comb begin
    cfgNext = cfgQ;
    if (wrCtrl) begin
      cfgNext.runEn      = wrData[BIT_EN];
      cfgNext.irqEn      = wrData[BIT_IE];
      cfgNext.autoReload = wrData[BIT_AR];
      cfgNext.polarity   = wrData[BIT_POL];
      cfgNext.mode       = wrData[BIT_MODE +: MODE_W];
    end
  end

  assign startNow  = wrCtrl && wrData[BIT_START] && wrData[BIT_EN]
                     && (wrData[BIT_MODE +: MODE_W] == MODE_SOFT);
  assign decNow    = runQ && cfgNext.runEn && countTick && !startNow;
  assign underflow = decNow && isZero;

  always_comb begin
    strobe.load = startNow || (underflow && cfgNext.autoReload);
    strobe.dec  = decNow;
  end

  always_comb begin
    flagNext = flagQ;
    if (underflow) begin
      flagNext = 1'b1;
    end else if (wrCtrl && !wrData[BIT_FLAG]) begin
      flagNext = 1'b0;
    end
  end

  always_comb begin
    runNext = runQ;
    if (startNow) begin
      runNext = 1'b1;
    end else if (!cfgNext.runEn) begin
      runNext = 1'b0;
    end else if (underflow && !cfgNext.autoReload) begin
      runNext = 1'b0;
    end
  end

  always_comb begin
    phaseNext = phaseQ;
    if (startNow) begin
      phaseNext = 1'b0;
    end else if (underflow && cfgNext.autoReload) begin
      phaseNext = ~phaseQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgQ   <= '0;
      flagQ  <= 1'b0;
      runQ   <= 1'b0;
      phaseQ <= 1'b0;
    end else begin
      cfgQ   <= cfgNext;
      flagQ  <= flagNext;
      runQ   <= runNext;
      phaseQ <= phaseNext;
    end
  end

  logic activeLevel;
  always_comb begin
    if (!runQ) begin
      activeLevel = 1'b0;
    end else if (cfgQ.autoReload) begin
      activeLevel = phaseQ;
    end else begin
      activeLevel = 1'b1;
    end
  end

  assign timerOut = cfgQ.polarity ^ activeLevel;
  assign irq      = flagQ & cfgQ.irqEn;

  always_comb begin
    ctrlWord                       = '0;
    ctrlWord[BIT_EN]               = cfgQ.runEn;
    ctrlWord[BIT_START]            = 1'b0;
    ctrlWord[BIT_IE]               = cfgQ.irqEn;
    ctrlWord[BIT_FLAG]             = flagQ;
    ctrlWord[BIT_AR]               = cfgQ.autoReload;
    ctrlWord[BIT_POL]              = cfgQ.polarity;
    ctrlWord[BIT_MODE +: MODE_W]   = cfgQ.mode;
  end

  // R3: an underflow leaves the flag set
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> flagQ);

  // R5: one-shot underflow stops the timer
  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !cfgNext.autoReload) |=> !runQ);

  // R6: reload underflow keeps running and flips the phase
  p_reload_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && cfgNext.autoReload) |=> runQ && (phaseQ != $past(phaseQ)));

  // R9: a valid start leaves the timer running
  p_start_runs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    startNow |=> runQ && cfgQ.runEn);

  // R11: never running while disabled
  p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgQ.runEn |-> !runQ);

  // R4: a rising request needs an enabled, set flag
  p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> cfgQ.irqEn && flagQ);

endmodule

// File: rtl/tick_reload_timer.sv
module tick_reload_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic              countTick,
  output logic              irq,
  output logic              timerOut
);

  dpStrobe_t        strobe;
  logic [CNT_W-1:0] count, reloadVal, ctrlWord;
  logic             isZero;
  logic             wrCtrl, wrReload;

  assign wrCtrl   = wrEn && (wrAddr == ADDR_W'(ADDR_CTRL));
  assign wrReload = wrEn && (wrAddr == ADDR_W'(ADDR_RELOAD));

  tmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrCtrl    (wrCtrl),
    .wrData    (wrData),
    .countTick (countTick),
    .isZero    (isZero),
    .strobe    (strobe),
    .ctrlWord  (ctrlWord),
    .irq       (irq),
    .timerOut  (timerOut)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrReload  (wrReload),
    .wrData    (wrData),
    .strobe    (strobe),
    .count     (count),
    .reloadVal (reloadVal),
    .isZero    (isZero)
  );

  always_comb begin
    unique case (rdAddr)
      ADDR_W'(ADDR_CTRL):   rdData = ctrlWord;
      ADDR_W'(ADDR_RELOAD): rdData = reloadVal;
      ADDR_W'(ADDR_COUNT):  rdData = count;
      default:              rdData = '0;
    endcase
  end

endmodule

// File: tb/tick_reload_timer_bench.sv
`timescale 1ns/1ps
module tick_reload_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = 2'd2;
  logic [15:0] rdData;
  logic        countTick = 1'b0;
  logic        irq, timerOut;

  int vectors = 0;
  int fails = 0;

  // model state
  logic [15:0] mCount = '0, mReload = '0;
  logic mEn = 0, mIe = 0, mAr = 0, mPol = 0, mFlag = 0, mRun = 0, mPhase = 0;
  logic [2:0] mMode = '0;

  always #5 clk = ~clk;

  tick_reload_timer u_tick_reload_timer (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .countTick(countTick),
    .irq(irq), .timerOut(timerOut)
  );

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mCtrl();
    return {7'd0, mMode, mPol, mAr, mFlag, mIe, 1'b0, mEn};
  endfunction

  function automatic logic mOut();
    return mPol ^ (mRun ? (mAr ? mPhase : 1'b1) : 1'b0);
  endfunction

  // compare the live outputs against the model
  task automatic compareAll();
    rdAddr = 2'd2;
    #1;
    chk(mAr ? "R6" : "R5", "count", rdData, mCount);
    chk(mAr ? "R8" : "R7", "timerOut", {15'd0, timerOut}, {15'd0, mOut()});
    chk("R4", "irq", {15'd0, irq}, {15'd0, mFlag & mIe});
  endtask

  task automatic readReg(input logic [1:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    rdAddr = a;
    #1;
    chk(req, "register", rdData, exp);
    rdAddr = 2'd2;
  endtask

  // one clock: check, drive, edge, update model
  task automatic cycle(input logic we, input logic [1:0] a, input logic [15:0] d, input logic tk);
    logic nEn, nAr, start, dec, uf;
    @(negedge clk);
    compareAll();
    wrEn = we; wrAddr = a; wrData = d; countTick = tk;
    @(posedge clk);
    #1;
    wrEn = 1'b0; countTick = 1'b0;
    nEn = (we && a == 2'd0) ? d[0] : mEn;
    nAr = (we && a == 2'd0) ? d[4] : mAr;
    start = we && a == 2'd0 && d[1] && d[0] && d[8:6] == 3'b000;
    dec = mRun && nEn && tk && !start;
    uf = dec && (mCount == 16'd0);
    if (start || (uf && nAr)) mCount = mReload;
    else if (dec) mCount = mCount - 16'd1;
    if (uf) mFlag = 1'b1;
    else if (we && a == 2'd0 && !d[3]) mFlag = 1'b0;
    if (start) mRun = 1'b1;
    else if (!nEn) mRun = 1'b0;
    else if (uf && !nAr) mRun = 1'b0;
    if (start) mPhase = 1'b0;
    else if (uf && nAr) mPhase = ~mPhase;
    if (we && a == 2'd1) mReload = d;
    if (we && a == 2'd0) begin
      mEn = d[0]; mIe = d[2]; mAr = d[4]; mPol = d[5]; mMode = d[8:6];
    end
  endtask

  function automatic logic [15:0] ctl(input logic en, input logic st, input logic ie,
                                      input logic fl, input logic ar, input logic pol,
                                      input logic [2:0] md);
    return {7'd0, md, pol, ar, fl, ie, st, en};
  endfunction

  initial begin
    logic [15:0] rls [4] = '{16'd0, 16'd1, 16'd2, 16'd5};
    repeat (3) @(posedge clk);
    // R1 reset state
    readReg(2'd0, 16'd0, "R1");
    readReg(2'd1, 16'd0, "R1");
    readReg(2'd2, 16'd0, "R1");
    @(negedge clk);
    chk("R1", "irq/timerOut", {14'd0, irq, timerOut}, 16'd0);
    rst_n = 1'b1;
    cycle(0, 0, 0, 1);

    for (int ar = 0; ar < 2; ar++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int ri = 0; ri < 4; ri++) begin
          for (int tp = 0; tp < 2; tp++) begin
            logic ie;
            ie = logic'((ri + tp) & 1);
            cycle(1, 2'd1, rls[ri], 0);
            // R9: enable and start in one write
            cycle(1, 2'd0, ctl(1, 1, ie, 1, logic'(ar), logic'(pol), 3'b000), 0);
            for (int k = 0; k < (int'(rls[ri]) + 1) * 3 + 4; k++)
              cycle(0, 0, 0, tp == 0 ? 1'b1 : logic'(k % 3 == 0));
            // R10 start bit reads 0; R3 flag visible
            readReg(2'd0, mCtrl(), "R10");
            // R3: writing 1 to the flag keeps it
            cycle(1, 2'd0, ctl(1, 0, ie, 1, logic'(ar), logic'(pol), 3'b000), 0);
            readReg(2'd0, mCtrl(), "R3");
            // R3: writing 0 clears it
            cycle(1, 2'd0, ctl(1, 0, ie, 0, logic'(ar), logic'(pol), 3'b000), 0);
            readReg(2'd0, mCtrl(), "R3");
            if (ar == 0) begin
              // R5: restart after one-shot stop
              cycle(1, 2'd0, ctl(1, 1, ie, 1, 1'b0, logic'(pol), 3'b000), 0);
              cycle(0, 0, 0, 1);
              cycle(0, 0, 0, 0);
            end
            // R11: disable freezes count and idles output
            cycle(1, 2'd0, ctl(0, 0, ie, 1, logic'(ar), logic'(pol), 3'b000), 1);
            cycle(0, 0, 0, 1);
            cycle(0, 0, 0, 1);
            @(negedge clk);
            chk("R11", "timerOut idle", {15'd0, timerOut}, {15'd0, logic'(pol)});
          end
        end
      end
    end

    // R9: start with enable 0 is ignored
    cycle(1, 2'd1, 16'd7, 0);
    cycle(1, 2'd0, ctl(0, 1, 0, 0, 0, 0, 3'b000), 1);
    cycle(0, 0, 0, 1);
    readReg(2'd2, mCount, "R9");
    // R9: start with nonzero mode is ignored
    cycle(1, 2'd0, ctl(1, 1, 0, 0, 0, 0, 3'b001), 1);
    cycle(0, 0, 0, 1);
    readReg(2'd2, mCount, "R9");
    @(negedge clk);
    chk("R9", "timerOut", {15'd0, timerOut}, 16'd0);
    // R2: ticks counted only when high
    cycle(1, 2'd0, ctl(1, 1, 0, 0, 0, 0, 3'b000), 0);
    for (int k = 0; k < 6; k++) cycle(0, 0, 0, logic'(k & 1));
    readReg(2'd2, 16'd4, "R2");
    cycle(0, 0, 0, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule